// File: doc/BRIEF.md
# Block Transfer Counter with Interrupt Flags

This block supervises a byte-oriented block transfer between a word FIFO and the data path of a NAND flash device. Software loads a byte count, picks a direction (toward the device or from it) and sets a run bit. The count drops by one for every byte the data path reports as moved, and it halts at zero.

Two interrupt sources are kept: one for transfer-count completion and one for a rising edge on the device ready line. Each source has a raw flag, an enable bit, a software set port and a write-one-to-clear port. A single interrupt line is driven from the enabled raw flags. A status word reports the ready level and whether either FIFO still holds data. A request line tells the external DMA engine when enough room or data is present: one word in single mode, or a burst's worth in burst mode.

Registers are reached through a simple write strobe with a word address. Reads are combinational from the same address.

Top module: `xfer_count_irq`

## Requirements
- R1: After reset the run bit, configuration, raw flags, enables and count all read 0, and `irqOut`, `dmaReq` and `xferActive` are low.
- R2: Register words are: 0 control (bit 0 run), 1 configuration (bit 1 direction, 1 means from device; bit 2 burst), 2 status, 3 raw flags, 4 enables, 5 set port, 6 clear port, 7 count. Writable words read back what was written, masked to their fields. Words 5 and 6 read as 0.
- R3: While the run bit is 1 and the count is non-zero, each clock with `byteDone` high lowers the count by exactly one. With the run bit at 0, `byteDone` leaves the count unchanged.
- R4: The count never wraps below zero. Further `byteDone` pulses at zero leave it at 0, and `xferActive` is low whenever the count is 0.
- R5: Raw flag bit 1 (transfer done) sets on the clock where a moved byte takes the count from 1 to 0. Loading 0 into the count by a write does not set it.
- R6: Raw flag bit 0 (ready) sets on the clock that samples a rising edge of `devReady`. A steady high level or a falling edge does not set it.
- R7: Writing ones to word 5 sets the matching raw flags. Zero bits leave flags as they are.
- R8: Writing ones to word 6 clears the matching raw flags. A hardware event on the same flag in the same clock wins, and the flag stays set.
- R9: `irqOut` is high exactly when some raw flag is set and its enable bit (same bit positions in word 4) is 1.
- R10: Status word 2 gives bit 0 = `devReady` level, bit 1 = controller FIFO level non-zero, bit 2 = DMA FIFO level non-zero.
- R11: `dmaReq` is high only while the transfer is active. From-device mode needs a DMA FIFO level of at least the threshold. To-device mode needs free space (depth minus level) of at least the threshold. The threshold is 1 word in single mode and 4 words in burst mode.
- R12: Clearing the run bit mid-transfer freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address for writes and reads |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| byteDone | input | 1 | One byte moved by the data path this clock |
| devReady | input | 1 | Device ready line |
| dmaFifoLevel | input | 5 | Words held in the DMA-side FIFO |
| ctrlFifoLevel | input | 5 | Words held in the controller-side FIFO |
| xferActive | output | 1 | Run bit set and count non-zero |
| dmaReq | output | 1 | DMA transfer request |
| irqOut | output | 1 | Masked interrupt |

## Verification
A wrong count shows at once on word 7 and on `xferActive`. It also shows one moved byte later as a done flag that sets too early, too late or never, and that error reaches `irqOut` in the same clock once the source is enabled. A wrong flag priority between the clear port and a hardware event leaves raw word 3 wrong on the clock after the collision. A wrong FIFO threshold or direction choice shows combinationally on `dmaReq` as soon as the level input crosses the boundary.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 2;
  localparam int SRC_RDY = 0;
  localparam int SRC_TC  = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_CFG   = 3'd1,
    ADDR_STAT  = 3'd2,
    ADDR_RAW   = 3'd3,
    ADDR_EN    = 3'd4,
    ADDR_SET   = 3'd5,
    ADDR_CLR   = 3'd6,
    ADDR_COUNT = 3'd7
  } regAddr_e;

  // Strobes from control decode to datapath and flag bank
  typedef struct packed {
    logic               ldCtrl;
    logic               ldCfg;
    logic               ldEn;
    logic               ldCount;
    logic [NUM_SRC-1:0] swSet;
    logic [NUM_SRC-1:0] swClr;
    logic               rdyEdge;
  } strobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] flagBits,
  input  logic               devReady,
  output strobe_t            stb
);
  logic     readyQ;
  regAddr_e addrE;

  assign addrE = regAddr_e'(regAddr);

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= devReady;
  end

  always_comb begin
    stb         = '0;
    stb.rdyEdge = devReady & ~readyQ;
    if (regWr) begin
      case (addrE)
        ADDR_CTRL:  stb.ldCtrl  = 1'b1;
        ADDR_CFG:   stb.ldCfg   = 1'b1;
        ADDR_EN:    stb.ldEn    = 1'b1;
        ADDR_COUNT: stb.ldCount = 1'b1;
        ADDR_SET:   stb.swSet   = flagBits;
        ADDR_CLR:   stb.swClr   = flagBits;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwEvt,
  input  logic [NUM_SRC-1:0] swSet,
  input  logic [NUM_SRC-1:0] swClr,
  input  logic               ldEn,
  input  logic [NUM_SRC-1:0] enIn,
  output logic [NUM_SRC-1:0] rawInt,
  output logic [NUM_SRC-1:0] intEn,
  output logic               irqOut
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)                      rawInt[g] <= 1'b0;
      else if (hwEvt[g] || swSet[g])  rawInt[g] <= 1'b1;
      else if (swClr[g])              rawInt[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     intEn <= '0;
    else if (ldEn) intEn <= enIn;
  end

  assign irqOut = |(rawInt & intEn);
endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int BURST_WORDS = 4,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               byteDone,
  input  logic               devReady,
  input  logic [LVL_W-1:0]   dmaFifoLevel,
  input  logic [LVL_W-1:0]   ctrlFifoLevel,
  input  logic [NUM_SRC-1:0] rawInt,
  input  logic [NUM_SRC-1:0] intEn,
  output logic               tcEvt,
  output logic               xferActive,
  output logic               dmaReq,
  output logic [CNT_W-1:0]   cntVal,
  output logic [DATA_W-1:0]  regRdata
);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [LVL_W-1:0] DEPTH_L   = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] SINGLE_L  = LVL_W'(1);
  localparam logic [LVL_W-1:0] BURST_L   = LVL_W'(BURST_WORDS);

  logic             startQ;
  logic             dirQ;
  logic             burstQ;
  logic [CNT_W-1:0] cntQ;
  logic [LVL_W-1:0] availWords;
  logic [LVL_W-1:0] needWords;
  logic             unusedBits;
  regAddr_e         addrE;

  assign unusedBits = ^regWdata;
  assign addrE      = regAddr_e'(regAddr);

  assign xferActive = startQ && (cntQ != '0);
  assign tcEvt      = xferActive && byteDone && (cntQ == CNT_ONE) && !stb.ldCount;
  assign cntVal     = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      dirQ   <= 1'b0;
      burstQ <= 1'b0;
    end else begin
      if (stb.ldCtrl) startQ <= regWdata[0];
      if (stb.ldCfg) begin
        dirQ   <= regWdata[1];
        burstQ <= regWdata[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        cntQ <= '0;
    else if (stb.ldCount)             cntQ <= regWdata[CNT_W-1:0];
    else if (xferActive && byteDone)  cntQ <= cntQ - CNT_ONE;
  end

  // Room toward the device, or data from it, measured in FIFO words
  assign availWords = dirQ ? dmaFifoLevel : (DEPTH_L - dmaFifoLevel);
  assign needWords  = burstQ ? BURST_L : SINGLE_L;
  assign dmaReq     = xferActive && (availWords >= needWords);

  always_comb begin
    regRdata = '0;
    case (addrE)
      ADDR_CTRL:  regRdata[0] = startQ;
      ADDR_CFG:   regRdata[2:1] = {burstQ, dirQ};
      ADDR_STAT:  regRdata[2:0] = {dmaFifoLevel != '0, ctrlFifoLevel != '0, devReady};
      ADDR_RAW:   regRdata[NUM_SRC-1:0] = rawInt;
      ADDR_EN:    regRdata[NUM_SRC-1:0] = intEn;
      ADDR_COUNT: regRdata[CNT_W-1:0] = cntQ;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/xfer_count_irq.sv
module xfer_count_irq
  import xfer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int BURST_WORDS = 4,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              byteDone,
  input  logic              devReady,
  input  logic [LVL_W-1:0]  dmaFifoLevel,
  input  logic [LVL_W-1:0]  ctrlFifoLevel,
  output logic              xferActive,
  output logic              dmaReq,
  output logic              irqOut
);
  strobe_t            stb;
  logic               tcEvt;
  logic [CNT_W-1:0]   cntVal;
  logic [NUM_SRC-1:0] rawInt;
  logic [NUM_SRC-1:0] intEn;
  logic [NUM_SRC-1:0] hwEvt;

  assign hwEvt[SRC_TC]  = tcEvt;
  assign hwEvt[SRC_RDY] = stb.rdyEdge;

  xfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .flagBits (regWdata[NUM_SRC-1:0]),
    .devReady (devReady),
    .stb      (stb)
  );

  xfer_dp #(
    .CNT_W       (CNT_W),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .BURST_WORDS (BURST_WORDS),
    .LVL_W       (LVL_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .byteDone      (byteDone),
    .devReady      (devReady),
    .dmaFifoLevel  (dmaFifoLevel),
    .ctrlFifoLevel (ctrlFifoLevel),
    .rawInt        (rawInt),
    .intEn         (intEn),
    .tcEvt         (tcEvt),
    .xferActive    (xferActive),
    .dmaReq        (dmaReq),
    .cntVal        (cntVal),
    .regRdata      (regRdata)
  );

  irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .hwEvt  (hwEvt),
    .swSet  (stb.swSet),
    .swClr  (stb.swClr),
    .ldEn   (stb.ldEn),
    .enIn   (regWdata[NUM_SRC-1:0]),
    .rawInt (rawInt),
    .intEn  (intEn),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/xfer_count_irq_chk.sv
module xfer_count_irq_chk
  import xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic               byteDone,
  input logic               devReady,
  input logic               xferActive,
  input logic               dmaReq,
  input logic               irqOut,
  input logic [CNT_W-1:0]   cntVal,
  input logic [NUM_SRC-1:0] rawInt,
  input logic [NUM_SRC-1:0] intEn,
  input logic               tcEvt,
  input logic               rdyEdge
);
  logic cntWrite;
  assign cntWrite = regWr && (regAddr == ADDR_COUNT);

  assert_count_no_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (cntVal <= $past(cntVal)));

  assert_count_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0 && !cntWrite) |=> (cntVal == '0));

  assert_tc_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && byteDone && cntVal == CNT_W'(1) && !cntWrite) |=> rawInt[SRC_TC]);

  assert_rdy_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devReady) |=> rawInt[SRC_RDY]);

  assert_sw_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_SET) |=>
      ((rawInt & $past(regWdata[NUM_SRC-1:0])) == $past(regWdata[NUM_SRC-1:0])));

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_CLR && regWdata[NUM_SRC-1:0] == '1 && !tcEvt && !rdyEdge)
      |=> (rawInt == '0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |-> !irqOut);

  assert_req_active_R11: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> xferActive);

  assert_frozen_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !cntWrite) |=> $stable(cntVal));
endmodule

bind xfer_count_irq xfer_count_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .byteDone   (byteDone),
  .devReady   (devReady),
  .xferActive (xferActive),
  .dmaReq     (dmaReq),
  .irqOut     (irqOut),
  .cntVal     (cntVal),
  .rawInt     (rawInt),
  .intEn      (intEn),
  .tcEvt      (tcEvt),
  .rdyEdge    (stb.rdyEdge)
);

// File: tb/xfer_count_irq_bench.sv
module xfer_count_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 5;

  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_STAT = 3'd2, A_RAW = 3'd3,
                         A_EN = 3'd4, A_SET = 3'd5, A_CLR = 3'd6, A_COUNT = 3'd7;

  typedef struct packed {
    logic        isWr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd4, 32'h0000_0003, 32'h0, 4'd2},   // enables
    '{1'b0, 3'd4, 32'h0, 32'h0000_0003, 4'd2},
    '{1'b1, 3'd1, 32'hFFFF_FFF6, 32'h0, 4'd2},   // config, extra bits masked
    '{1'b0, 3'd1, 32'h0, 32'h0000_0006, 4'd2},
    '{1'b1, 3'd7, 32'hABCD_1234, 32'h0, 4'd2},   // count, masked to 16 bits
    '{1'b0, 3'd7, 32'h0, 32'h0000_1234, 4'd2},
    '{1'b0, 3'd5, 32'h0, 32'h0, 4'd2},
    '{1'b0, 3'd6, 32'h0, 32'h0, 4'd2},
    '{1'b1, 3'd5, 32'h0000_0001, 32'h0, 4'd7},
    '{1'b0, 3'd3, 32'h0, 32'h0000_0001, 4'd7},
    '{1'b1, 3'd6, 32'h0000_0001, 32'h0, 4'd8},
    '{1'b0, 3'd3, 32'h0, 32'h0000_0000, 4'd8},
    '{1'b1, 3'd5, 32'h0000_0002, 32'h0, 4'd7},
    '{1'b1, 3'd5, 32'h0000_0000, 32'h0, 4'd7},
    '{1'b0, 3'd3, 32'h0, 32'h0000_0002, 4'd7},
    '{1'b1, 3'd6, 32'h0000_0001, 32'h0, 4'd8},   // clear of a bit that is not set
    '{1'b0, 3'd3, 32'h0, 32'h0000_0002, 4'd8},
    '{1'b1, 3'd6, 32'h0000_0003, 32'h0, 4'd8},
    '{1'b0, 3'd3, 32'h0, 32'h0000_0000, 4'd8},
    '{1'b1, 3'd4, 32'h0000_0000, 32'h0, 4'd2}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWr = 1'b0;
  logic [2:0]       regAddr = '0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic             byteDone = 1'b0;
  logic             devReady = 1'b0;
  logic [LVL_W-1:0] dmaFifoLevel = '0;
  logic [LVL_W-1:0] ctrlFifoLevel = '0;
  logic             xferActive, dmaReq, irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count_irq u_xfer_count_irq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .byteDone(byteDone), .devReady(devReady),
    .dmaFifoLevel(dmaFifoLevel), .ctrlFifoLevel(ctrlFifoLevel),
    .xferActive(xferActive), .dmaReq(dmaReq), .irqOut(irqOut)
  );

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regCheck(input logic [2:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    check(regRdata, exp, req);
  endtask

  task automatic pulseByte();
    @(negedge clk);
    byteDone = 1'b1;
    @(negedge clk);
    byteDone = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regCheck(A_CTRL, 0, "R1");
    regCheck(A_CFG, 0, "R1");
    regCheck(A_RAW, 0, "R1");
    regCheck(A_EN, 0, "R1");
    regCheck(A_COUNT, 0, "R1");
    check({29'b0, irqOut, dmaReq, xferActive}, 0, "R1");

    // Register table (R2, R7, R8)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) regWrite(VECS[i].addr, VECS[i].data);
      else              regCheck(VECS[i].addr, VECS[i].exp, reqName(VECS[i].req));
    end
    regWrite(A_CFG, 0);

    // R3: no counting while the run bit is clear
    regWrite(A_COUNT, 3);
    pulseByte();
    regCheck(A_COUNT, 3, "R3");
    regWrite(A_CTRL, 1);
    check(xferActive, 1, "R3");
    pulseByte();
    regCheck(A_COUNT, 2, "R3");
    pulseByte();
    regCheck(A_COUNT, 1, "R3");
    regWrite(A_EN, 2);
    check(irqOut, 0, "R9");
    regCheck(A_RAW, 0, "R5");
    pulseByte();
    regCheck(A_COUNT, 0, "R4");
    regCheck(A_RAW, 2, "R5");
    check(irqOut, 1, "R9");
    check(xferActive, 0, "R4");
    pulseByte();
    regCheck(A_COUNT, 0, "R4");
    regWrite(A_CLR, 2);
    check(irqOut, 0, "R9");

    // R12: stopping mid-transfer freezes the count
    regWrite(A_COUNT, 5);
    pulseByte();
    regCheck(A_COUNT, 4, "R12");
    regWrite(A_CTRL, 0);
    pulseByte();
    pulseByte();
    regCheck(A_COUNT, 4, "R12");

    // R5: loading zero does not raise the done flag
    regWrite(A_COUNT, 1);
    regWrite(A_COUNT, 0);
    regCheck(A_RAW, 0, "R5");

    // R6: ready edge
    regWrite(A_EN, 1);
    @(negedge clk); devReady = 1'b1;
    @(negedge clk); @(negedge clk);
    regCheck(A_RAW, 1, "R6");
    check(irqOut, 1, "R9");
    regWrite(A_CLR, 1);
    repeat (3) @(negedge clk);
    regCheck(A_RAW, 0, "R6");
    devReady = 1'b0;
    @(negedge clk); @(negedge clk);
    regCheck(A_RAW, 0, "R6");
    devReady = 1'b1;
    @(negedge clk); @(negedge clk);
    regCheck(A_RAW, 1, "R6");
    regWrite(A_CLR, 1);
    regCheck(A_RAW, 0, "R6");

    // R8: hardware event beats clear in the same clock
    regWrite(A_COUNT, 1);
    regWrite(A_CTRL, 1);
    @(negedge clk);
    byteDone = 1'b1; regWr = 1'b1; regAddr = A_CLR; regWdata = 32'h2;
    @(negedge clk);
    byteDone = 1'b0; regWr = 1'b0; regWdata = '0;
    regCheck(A_RAW, 2, "R8");
    regCheck(A_COUNT, 0, "R8");
    regWrite(A_CLR, 3);

    // R10: status word
    regCheck(A_STAT, 1, "R10");
    ctrlFifoLevel = 2;
    regCheck(A_STAT, 3, "R10");
    dmaFifoLevel = 5;
    regCheck(A_STAT, 7, "R10");
    devReady = 1'b0; ctrlFifoLevel = 0;
    regCheck(A_STAT, 4, "R10");
    dmaFifoLevel = 0;
    @(negedge clk);

    // R11: request thresholds
    regWrite(A_COUNT, 8);
    regWrite(A_CFG, 2);
    #1 check(dmaReq, 0, "R11");
    dmaFifoLevel = 1;
    #1 check(dmaReq, 1, "R11");
    regWrite(A_CFG, 6);
    dmaFifoLevel = 3;
    #1 check(dmaReq, 0, "R11");
    dmaFifoLevel = 4;
    #1 check(dmaReq, 1, "R11");
    regWrite(A_CFG, 4);
    dmaFifoLevel = 13;
    #1 check(dmaReq, 0, "R11");
    dmaFifoLevel = 12;
    #1 check(dmaReq, 1, "R11");
    regWrite(A_CFG, 0);
    dmaFifoLevel = 16;
    #1 check(dmaReq, 0, "R11");
    dmaFifoLevel = 15;
    #1 check(dmaReq, 1, "R11");
    regWrite(A_CTRL, 0);
    #1 check(dmaReq, 0, "R11");
    regWrite(A_CTRL, 1);
    regWrite(A_COUNT, 0);
    #1 check(dmaReq, 0, "R11");

    finish();
  end
endmodule